// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Pair with Error-Tagged Receive Entries

This block holds the character queues of a serial port. The receiver pushes each character into a receive queue, together with its parity-error and framing-error flags. Software reads an entry back as one 10-bit word, so each error stays attached to its own character. Software fills a byte-wide transmit queue, and the transmitter takes bytes from its head. Bit shifting, baud timing and interrupt generation are outside this block.

Software uses a small register port. One read-only index register packs both queue occupancies. A control register holds a queue enable bit and two self-clearing clear bits, one per queue. Each clear is run by its own instance of a three-state machine with the states `FL_IDLE`, `FL_CLR_A` and `FL_CLR_B`. The transitions are:
- `FL_IDLE` to `FL_CLR_A` when a clear is requested. The queue empties on this edge.
- `FL_IDLE` to `FL_IDLE` when no clear is requested.
- `FL_CLR_A` to `FL_CLR_B` unconditionally.
- `FL_CLR_B` to `FL_IDLE` unconditionally.

The clear bit reads as 1 while its machine is out of `FL_IDLE`. Software polls that bit until it reads 0.

Register addresses (`reg_addr`): 0 is the index register (read), 1 is control (read/write), 2 is transmit data (a write appends a byte), and 3 is receive data (a read returns the head entry and removes it).

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both queues are empty, and the index register and control register read as 0. `tx_data`, `rx_overrun`, `rx_underrun` and `tx_underrun` are 0.
- R2: A read at address 3 returns receive entries in arrival order. The data byte is in bits 7:0, the parity error in bit 8, the framing error in bit 9, and bits 15:10 are 0. The read value appears combinationally in the cycle of the read.
- R3: A write at address 2 appends `reg_wdata` to the transmit queue. `tx_data` shows the oldest byte, or 0 when the queue is empty or access is blocked. `tx_pop` removes the oldest byte at the clock edge.
- R4: The index register holds the transmit count (0 to 16) in bits 4:0 and the receive count (0 to 16) in bits 12:8. All other bits are 0, so bit 4 is 1 exactly when the transmit queue is full.
- R5: A receive push into a full queue is discarded. `rx_overrun` is high for exactly the one cycle after that edge, and the queue contents stay unchanged.
- R6: A receive read or a `tx_pop` on an empty queue returns 0. The matching underrun output (`rx_underrun` or `tx_underrun`) is high for the one cycle after that edge.
- R7: A transmit write into a full queue is discarded without a pulse. The count stays 16 and the head stays unchanged.
- R8: A control write with bit 2 empties the transmit queue, and a control write with bit 3 empties the receive queue, both at that edge. The bit then reads 1 for exactly two cycles and 0 afterwards. A clear request made while that clear is still running is ignored.
- R9: While a queue's clear is running, pushes and pops on that queue have no effect and raise no pulse.
- R10: Control bit 0 (0 after reset) enables queue access. While it is 0, every push and pop is ignored without a pulse, and it reads back at control bit 0.
- R11: `rx_almost_full` is high when the receive count is 12 or more. `tx_almost_empty` is high when the transmit count is 4 or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receiver delivers a character |
| rx_byte | input | 8 | Received data byte |
| rx_parity_err | input | 1 | Parity error flag of the character |
| rx_frame_err | input | 1 | Framing error flag of the character |
| rx_overrun | output | 1 | One-cycle pulse: push into a full receive queue was dropped |
| rx_underrun | output | 1 | One-cycle pulse: receive read from an empty queue |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_data | output | 8 | Head byte of the transmit queue |
| tx_underrun | output | 1 | One-cycle pulse: pop from an empty transmit queue |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from the address |
| rx_almost_full | output | 1 | Receive count at or above 12 |
| tx_almost_empty | output | 1 | Transmit count at or below 4 |

## Verification
`reg_rdata` and `tx_data` are combinational, so the bench compares a receive read value in the cycle of the read, before the edge that pops it. Queue counts, control bits and almost flags change at the edge that samples a request. The overrun and underrun pulses appear for the one cycle after that edge. The bench drives every request at the falling edge and lets one rising edge pass. It then compares the pulses, the index register, the control register, `tx_data` and the flags at the next falling edge against its own queue and clear-timer model. The model is updated with the same pre-edge conditions.

// File: rtl/ufq_pkg.sv
package ufq_pkg;

    typedef enum logic [1:0] {
        FL_IDLE  = 2'd0,
        FL_CLR_A = 2'd1,
        FL_CLR_B = 2'd2
    } flush_state_t;

    typedef enum logic [1:0] {
        RA_INDEX  = 2'd0,
        RA_CTRL   = 2'd1,
        RA_TXDATA = 2'd2,
        RA_RXDATA = 2'd3
    } reg_addr_t;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_TXCLR_BIT = 2;
    localparam int CTRL_RXCLR_BIT = 3;

endpackage

// File: rtl/ufq_flush_fsm.sv
module ufq_flush_fsm
    import ufq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic flush
);

    flush_state_t state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            FL_IDLE:  state_nx = start ? FL_CLR_A : FL_IDLE;
            FL_CLR_A: state_nx = FL_CLR_B;
            FL_CLR_B: state_nx = FL_IDLE;
            default:  state_nx = FL_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state_q != FL_IDLE);
        flush = (state_q == FL_IDLE) && start;
    end

    // R8: a clear holds busy for exactly two cycles
    p_clear_two_cycles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> busy ##1 busy ##1 !busy);

endmodule

// File: rtl/ufq_store.sv
module ufq_store #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             hold,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             over_pulse,
    output logic             under_pulse
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             full, empty, live, do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign live    = !hold && !flush;
    assign do_push = push && live && !full;
    assign do_pop  = pop && live && !empty;
    assign rdata   = (empty || hold) ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr      <= '0;
            rd_ptr      <= '0;
            count       <= '0;
            over_pulse  <= 1'b0;
            under_pulse <= 1'b0;
        end else begin
            over_pulse  <= push && live && full;
            under_pulse <= pop && live && empty;
            if (flush) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                count  <= '0;
            end else begin
                if (do_push) wr_ptr <= ptr_next(wr_ptr);
                if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
                count <= count + CW'(do_push) - CW'(do_pop);
            end
        end
    end

    // R4: occupancy never exceeds the depth
    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R5: a push into a full queue without a pop leaves it full
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !hold && !flush && full && !pop) |=> (count == CW'(DEPTH)));

    // R6: an underrun pulse follows only a cycle with an empty queue
    p_under_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        under_pulse |-> ($past(count) == '0));

    // R9: a blocked queue keeps its count and head
    p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !flush) |=> ($stable(count) && $stable(rd_ptr)));

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import ufq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int RX_AF_LEVEL = 12,
    parameter int TX_AE_LEVEL = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_push,
    input  logic [7:0]  rx_byte,
    input  logic        rx_parity_err,
    input  logic        rx_frame_err,
    output logic        rx_overrun,
    output logic        rx_underrun,
    input  logic        tx_pop,
    output logic [7:0]  tx_data,
    output logic        tx_underrun,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [7:0]  reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        rx_almost_full,
    output logic        tx_almost_empty
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int RXW = 10;

    logic          en_q;
    logic          ctrl_wr, tx_start, rx_start;
    logic          tx_busy, rx_busy, tx_flush, rx_flush;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [RXW-1:0] rx_head;

    assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
    assign tx_start = ctrl_wr && reg_wdata[CTRL_TXCLR_BIT];
    assign rx_start = ctrl_wr && reg_wdata[CTRL_RXCLR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (ctrl_wr) en_q <= reg_wdata[CTRL_EN_BIT];
    end

    ufq_flush_fsm u_tx_clr (
        .clk(clk), .rst_n(rst_n), .start(tx_start),
        .busy(tx_busy), .flush(tx_flush)
    );

    ufq_flush_fsm u_rx_clr (
        .clk(clk), .rst_n(rst_n), .start(rx_start),
        .busy(rx_busy), .flush(rx_flush)
    );

    ufq_store #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .flush(tx_flush), .hold(tx_busy || !en_q),
        .push(reg_wr && (reg_addr == RA_TXDATA)), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_data), .count(tx_cnt),
        .over_pulse(), .under_pulse(tx_underrun)
    );

    ufq_store #(.WIDTH(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .flush(rx_flush), .hold(rx_busy || !en_q),
        .push(rx_push), .wdata({rx_frame_err, rx_parity_err, rx_byte}),
        .pop(reg_rd && (reg_addr == RA_RXDATA)), .rdata(rx_head), .count(rx_cnt),
        .over_pulse(rx_overrun), .under_pulse(rx_underrun)
    );

    assign rx_almost_full  = (rx_cnt >= CW'(RX_AF_LEVEL));
    assign tx_almost_empty = (tx_cnt <= CW'(TX_AE_LEVEL));

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_INDEX:  reg_rdata = {3'b000, 5'(rx_cnt), 3'b000, 5'(tx_cnt)};
            RA_CTRL:   reg_rdata = 16'({rx_busy, tx_busy, 1'b0, en_q});
            RA_TXDATA: reg_rdata = '0;
            RA_RXDATA: reg_rdata = 16'(rx_head);
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: tb/uart_fifo_pair_test.sv
module uart_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_push, rx_parity_err, rx_frame_err, tx_pop, reg_wr, reg_rd;
    logic [7:0]  rx_byte, reg_wdata, tx_data;
    logic [1:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic        rx_overrun, rx_underrun, tx_underrun, rx_almost_full, tx_almost_empty;

    always #10 clk = ~clk;

    uart_fifo_pair uut (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err),
        .rx_overrun(rx_overrun), .rx_underrun(rx_underrun),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_underrun(tx_underrun),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_almost_full(rx_almost_full), .tx_almost_empty(tx_almost_empty)
    );

    int vectors = 0;
    int fails   = 0;
    logic [9:0] mrx[$];
    logic [7:0] mtx[$];
    int  txb = 0;
    int  rxb = 0;
    bit  men = 1'b0;

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] exp_index();
        return {3'd0, 5'(mrx.size()), 3'd0, 5'(mtx.size())};
    endfunction

    function automatic logic [15:0] exp_ctrl();
        return {12'd0, rxb > 0, txb > 0, 1'b0, men};
    endfunction

    function automatic logic [7:0] exp_txhead();
        return (men && txb == 0 && mtx.size() > 0) ? mtx[0] : 8'd0;
    endfunction

    task automatic check_state();
        reg_addr = 2'd0;
        #1 chk("R4 index register", reg_rdata, exp_index());
        reg_addr = 2'd1;
        #1 chk("R8 control readback", reg_rdata, exp_ctrl());
        chk("R3 tx head", 16'(tx_data), 16'(exp_txhead()));
        chk("R11 rx almost full", 16'(rx_almost_full), 16'(mrx.size() >= 12));
        chk("R11 tx almost empty", 16'(tx_almost_empty), 16'(mtx.size() <= 4));
    endtask

    task automatic step(input bit rpush, input logic [9:0] rword, input bit tpop,
                        input bit wr, input bit rd, input logic [1:0] addr,
                        input logic [7:0] wd);
        bit rlive, tlive, rfl, tfl, exp_ro, exp_ru, exp_tu;
        bit rpop_ok, rpush_ok, tpop_ok, tpush_ok;
        rx_push = rpush; rx_byte = rword[7:0];
        rx_parity_err = rword[8]; rx_frame_err = rword[9];
        tx_pop = tpop; reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        #1;
        rlive = men && rxb == 0;
        tlive = men && txb == 0;
        rfl = wr && addr == 2'd1 && wd[3] && rxb == 0;
        tfl = wr && addr == 2'd1 && wd[2] && txb == 0;
        if (rd && addr == 2'd3)
            chk("R2 rx read value", reg_rdata,
                {6'd0, (rlive && mrx.size() > 0) ? mrx[0] : 10'd0});
        exp_ro = rpush && rlive && !rfl && mrx.size() == 16;
        exp_ru = rd && addr == 2'd3 && rlive && !rfl && mrx.size() == 0;
        exp_tu = tpop && tlive && !tfl && mtx.size() == 0;
        rpop_ok  = rlive && !rfl && rd && addr == 2'd3 && mrx.size() > 0;
        rpush_ok = rlive && !rfl && rpush && mrx.size() < 16;
        tpop_ok  = tlive && !tfl && tpop && mtx.size() > 0;
        tpush_ok = tlive && !tfl && wr && addr == 2'd2 && mtx.size() < 16;
        if (rfl) mrx.delete();
        if (rpop_ok) void'(mrx.pop_front());
        if (rpush_ok) mrx.push_back(rword);
        if (tfl) mtx.delete();
        if (tpop_ok) void'(mtx.pop_front());
        if (tpush_ok) mtx.push_back(wd);
        if (rxb > 0) rxb--; else if (rfl) rxb = 2;
        if (txb > 0) txb--; else if (tfl) txb = 2;
        if (wr && addr == 2'd1) men = wd[0];
        @(posedge clk);
        @(negedge clk);
        rx_push = 1'b0; tx_pop = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R5 rx overrun pulse", 16'(rx_overrun), 16'(exp_ro));
        chk("R6 rx underrun pulse", 16'(rx_underrun), 16'(exp_ru));
        chk("R6 tx underrun pulse", 16'(tx_underrun), 16'(exp_tu));
        check_state();
    endtask

    task automatic idle();
        step(1'b0, 10'd0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst_n = 1'b0;
        rx_push = 0; rx_byte = 0; rx_parity_err = 0; rx_frame_err = 0;
        tx_pop = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reg_addr = 2'd0;
        #1 chk("R1 index after reset", reg_rdata, 16'd0);
        reg_addr = 2'd1;
        #1 chk("R1 control after reset", reg_rdata, 16'd0);
        chk("R1 tx_data after reset", 16'(tx_data), 16'd0);
        chk("R1 pulses after reset", 16'({rx_overrun, rx_underrun, tx_underrun}), 16'd0);
        check_state();

        // R10: disabled after reset, access ignored
        step(1'b1, 10'h155, 1'b1, 1'b1, 1'b0, 2'd2, 8'hAA);
        step(1'b0, 10'd0, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0);
        reg_addr = 2'd0;
        #1 chk("R10 disabled queues stay empty", reg_rdata, 16'd0);

        // enable
        step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h01);

        // R2 / R5: fill receive queue, overflow, drain, underflow
        for (int i = 0; i < 17; i++)
            step(1'b1, 10'($urandom), 1'b0, 1'b0, 1'b0, 2'd0, 8'd0);
        reg_addr = 2'd0;
        #1 chk("R5 rx count stays 16", reg_rdata, {3'd0, 5'd16, 8'd0});
        for (int i = 0; i < 17; i++)
            step(1'b0, 10'd0, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0);

        // R3 / R7: fill transmit queue, extra write dropped, drain, underflow
        for (int i = 0; i < 17; i++)
            step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd2, 8'(i + 8'h30));
        reg_addr = 2'd0;
        #1 chk("R7 tx full count", reg_rdata, 16'd16);
        chk("R7 tx head unchanged", 16'(tx_data), 16'h30);
        for (int i = 0; i < 17; i++)
            step(1'b0, 10'd0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0);

        // R8 / R9: clear receive queue, pushes during clear ignored
        for (int i = 0; i < 5; i++)
            step(1'b1, 10'(i + 3), 1'b0, 1'b1, 1'b0, 2'd2, 8'(i));
        step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h09);
        step(1'b1, 10'h3FF, 1'b0, 1'b1, 1'b0, 2'd1, 8'h09);
        step(1'b1, 10'h3FE, 1'b0, 1'b0, 1'b1, 2'd3, 8'd0);
        reg_addr = 2'd0;
        #1 chk("R9 rx pushes ignored during clear", reg_rdata, 16'd5);
        step(1'b1, 10'h201, 1'b0, 1'b1, 1'b0, 2'd1, 8'h05);
        step(1'b0, 10'd0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
        idle(); idle();

        // R10: disable, everything ignored, then re-enable
        step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h00);
        step(1'b1, 10'h0F0, 1'b1, 1'b0, 1'b1, 2'd3, 8'd0);
        step(1'b0, 10'd0, 1'b1, 1'b1, 1'b0, 2'd2, 8'h77);
        reg_addr = 2'd0;
        #1 chk("R10 counts frozen while disabled", reg_rdata, 16'h0100);
        step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h01);

        // random traffic
        for (int n = 0; n < 1500; n++) begin
            int r;
            bit wr, rd;
            logic [1:0] a;
            logic [7:0] wd;
            r = int'($urandom % 32);
            wr = 1'b0; rd = 1'b0; a = 2'd0; wd = 8'($urandom);
            if (r < 10) begin wr = 1'b1; a = 2'd2; end
            else if (r < 20) begin rd = 1'b1; a = 2'd3; end
            else if (r == 20) begin
                wr = 1'b1; a = 2'd1;
                wd = {4'd0, wd[3:2], 1'b0, ($urandom % 6) != 0};
            end
            step(($urandom % 2) == 1, 10'($urandom), ($urandom % 3) == 0, wr, rd, a, wd);
        end
        step(1'b0, 10'd0, 1'b0, 1'b1, 1'b0, 2'd1, 8'h01);
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule